// File: doc/BRIEF.md
# Video Line Attribute Bit Inserter

This block overlays a short serial attribute code on one chosen line of an interlaced analog-style video stream. The timing generator supplies a line-start pulse and the line number within the frame. A format select chooses between 625-line and 525-line timing. In 625-line timing the block sends a 14-bit wide-screen signaling word once per frame. In 525-line timing it sends a 14-bit copy-generation word followed by a 6-bit check code, once in each field. One 20-bit data register and one enable bit serve both formats. The field layout, the target lines and the logic-one amplitude all follow from the format select.

The output replaces picture samples. While `ovr_valid` is high, the video path drives `ovr_level` in place of the picture sample. Bits go out least significant first, and each bit lasts a programmable number of clocks. The first bit starts a programmable number of clocks after the line start. Register contents, offset and bit period are captured at the start of the target line, so a write later in that line cannot alter a burst already under way. A status flag reports whether the check code stored in the register matches the value computed from the data bits.

Top module: `vline_attr_inserter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `ovr_valid` is 0, `ovr_level` is 0 and `crc_err` is 0.
- R2: With `fmt_525`=0, a line start on frame line 23 (with enable set) sends 14 bits, register bit 0 first and bit 13 last. Bits [19:14] have no effect on the output.
- R3: With `fmt_525`=1, a line start on frame line 20 or frame line 283 (with enable set) sends 20 bits, register bit 0 first and bit 19 last. Bits [13:0] are data and bits [19:14] are the check code.
- R4: Let O be the captured start offset and P the captured bit period, where a programmed period of 0 counts as 1. Bit j is driven with `ovr_valid`=1 in cycles O+1+j·P through O+(j+1)·P. Cycles are counted after the cycle in which `line_start` was high. `ovr_valid` is 0 in all other cycles.
- R5: While `ovr_valid`=1, a zero bit drives the blanking code and a one bit drives blank + (white−blank)·5/7 in 625 mode or blank + (white−blank)·7/10 in 525 mode. Integer division is used, so the defaults 60 and 200 give 60, 160 and 158. While `ovr_valid`=0, `ovr_level` is 0.
- R6: A line start with `attr_en`=0, or on a line that is not a target for the current format, produces no burst.
- R7: Changes to `attr_data`, `attr_en`, `start_ofs` or `bit_clks` after the line start do not affect the burst in progress.
- R8: On each accepted 525 line, `crc_err` is set to 1 if and only if CRC(data[13:0]) ≠ data[19:14], with CRC bit k stored at register bit 14+k. The CRC register is preset to 6'h3F. For each data bit, taken bit 0 first: f = crc[5] ^ d, then crc = {crc[4:0],0} ^ (f ? 6'h03 : 0). An accepted 625 line clears `crc_err`. Otherwise the flag holds its value.
- R9: Any line start that does not begin a new burst ends a burst in progress. From the next cycle on, `ovr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_525 | input | 1 | 1 = 525-line timing, 0 = 625-line timing |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| line_num | input | 10 | Frame line number, valid with `line_start` |
| attr_data | input | 20 | Shared attribute data register |
| attr_en | input | 1 | Insertion enable |
| start_ofs | input | 8 | Clocks from the line start to the first bit |
| bit_clks | input | 4 | Clocks per bit (0 counts as 1) |
| ovr_valid | output | 1 | Replace the picture sample with `ovr_level` |
| ovr_level | output | 10 | Sample code to drive during override |
| crc_err | output | 1 | Stored check code disagrees with computed CRC |

## Verification
The checker watches four properties on every cycle. The override level is always zero, blanking or one of the two logic-one codes. A line start that is disabled or off-target forces the override low on the next cycle. The CRC flag moves only right after a line start. An accepted 625 line always leaves the flag clear. Only the bench scenarios can show the bit order, the exact per-cycle window for each offset and bit period, the check code arithmetic, and the immunity of a burst to register writes made during the line. The bench covers these with directed corners and seeded random lines compared against a cycle-by-cycle model.

// File: rtl/vla_pkg.sv
package vla_pkg;

    localparam int DATA_W = 20;
    localparam int PAY_W  = 14;
    localparam int CRC_W  = 6;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic {
        FMT_625 = 1'b0,
        FMT_525 = 1'b1
    } vfmt_e;

    // burst description captured at the start of a target line
    typedef struct packed {
        logic [DATA_W-1:0] bits;
        logic [CNT_W-1:0]  nbits;
        vfmt_e             fmt;
    } burst_t;

    // check code over the payload, preset to all ones, payload bit 0 first
    function automatic logic [CRC_W-1:0] crc6(input logic [PAY_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic             f;
        c = '1;
        for (int i = 0; i < PAY_W; i++) begin
            f = c[CRC_W-1] ^ d[i];
            c = {c[CRC_W-2:0], 1'b0} ^ (f ? 6'h03 : 6'h00);
        end
        return c;
    endfunction

    // amplitude as a fraction of the blank-to-white span
    function automatic int frac_level(input int blank, input int white,
                                      input int num, input int den);
        return blank + ((white - blank) * num) / den;
    endfunction

endpackage

// File: rtl/vla_line_match.sv
module vla_line_match
    import vla_pkg::*;
#(
    parameter int LINE_W   = 10,
    parameter int LINE_625 = 23,
    parameter int LINE_5A  = 20,
    parameter int LINE_5B  = 283
) (
    input  logic              fmt_525,
    input  logic [LINE_W-1:0] line_num,
    input  logic              attr_en,
    input  logic [DATA_W-1:0] attr_data,
    output logic              hit,
    output burst_t            burst
);
    localparam logic [LINE_W-1:0] T625 = LINE_W'(LINE_625);
    localparam logic [LINE_W-1:0] T5A  = LINE_W'(LINE_5A);
    localparam logic [LINE_W-1:0] T5B  = LINE_W'(LINE_5B);

    logic target;

    always_comb begin
        if (fmt_525) target = (line_num == T5A) || (line_num == T5B);
        else         target = (line_num == T625);
        hit = attr_en && target;
    end

    always_comb begin
        burst.fmt = fmt_525 ? FMT_525 : FMT_625;
        if (fmt_525) begin
            burst.bits  = attr_data;
            burst.nbits = CNT_W'(DATA_W);
        end else begin
            // upper bits never leave in this format
            burst.bits  = {{(DATA_W-PAY_W){1'b0}}, attr_data[PAY_W-1:0]};
            burst.nbits = CNT_W'(PAY_W);
        end
    end

endmodule

// File: rtl/vla_serializer.sv
module vla_serializer
    import vla_pkg::*;
#(
    parameter int OFS_W  = 8,
    parameter int BCLK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              abort,
    input  burst_t            burst,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [BCLK_W-1:0] bclks,
    output logic              valid,
    output logic              cur_bit
);
    logic              act;
    logic [OFS_W-1:0]  dly;
    logic [BCLK_W-1:0] bcnt;
    logic [BCLK_W-1:0] bper;
    logic [CNT_W-1:0]  left;
    logic [DATA_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= 1'b0;
            dly  <= '0;
            bcnt <= '0;
            bper <= BCLK_W'(1);
            left <= '0;
            sh   <= '0;
        end else if (load) begin
            act  <= 1'b1;
            dly  <= ofs;
            bcnt <= '0;
            bper <= (bclks == '0) ? BCLK_W'(1) : bclks;
            left <= burst.nbits - CNT_W'(1);
            sh   <= burst.bits;
        end else if (abort) begin
            act <= 1'b0;
        end else if (act) begin
            if (dly != '0) begin
                dly <= dly - OFS_W'(1);
            end else if (bcnt == bper - BCLK_W'(1)) begin
                bcnt <= '0;
                sh   <= sh >> 1;
                if (left == '0) act <= 1'b0;
                else            left <= left - CNT_W'(1);
            end else begin
                bcnt <= bcnt + BCLK_W'(1);
            end
        end
    end

    assign valid   = act && (dly == '0);
    assign cur_bit = sh[0];

endmodule

// File: rtl/vline_attr_inserter.sv
module vline_attr_inserter
    import vla_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int OFS_W     = 8,
    parameter int BCLK_W    = 4,
    parameter int LVL_W     = 10,
    parameter int BLANK_LVL = 60,
    parameter int WHITE_LVL = 200,
    parameter int LINE_625  = 23,
    parameter int LINE_5A   = 20,
    parameter int LINE_5B   = 283
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fmt_525,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic [19:0]       attr_data,
    input  logic              attr_en,
    input  logic [OFS_W-1:0]  start_ofs,
    input  logic [BCLK_W-1:0] bit_clks,
    output logic              ovr_valid,
    output logic [LVL_W-1:0]  ovr_level,
    output logic              crc_err
);
    localparam logic [LVL_W-1:0] LVL_BLANK = LVL_W'(BLANK_LVL);
    localparam logic [LVL_W-1:0] LVL_ONE_W = LVL_W'(frac_level(BLANK_LVL, WHITE_LVL, 5, 7));
    localparam logic [LVL_W-1:0] LVL_ONE_C = LVL_W'(frac_level(BLANK_LVL, WHITE_LVL, 7, 10));

    logic             hit;
    burst_t           burst;
    logic             load;
    logic             abort;
    logic             cur_bit;
    logic [LVL_W-1:0] lvl_one;

    vla_line_match #(
        .LINE_W  (LINE_W),
        .LINE_625(LINE_625),
        .LINE_5A (LINE_5A),
        .LINE_5B (LINE_5B)
    ) u_match (
        .fmt_525  (fmt_525),
        .line_num (line_num),
        .attr_en  (attr_en),
        .attr_data(attr_data),
        .hit      (hit),
        .burst    (burst)
    );

    assign load  = line_start && hit;
    assign abort = line_start && !hit;

    vla_serializer #(
        .OFS_W (OFS_W),
        .BCLK_W(BCLK_W)
    ) u_ser (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .abort  (abort),
        .burst  (burst),
        .ofs    (start_ofs),
        .bclks  (bit_clks),
        .valid  (ovr_valid),
        .cur_bit(cur_bit)
    );

    // amplitude and check status follow the format captured with the line
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_one <= LVL_ONE_W;
            crc_err <= 1'b0;
        end else if (load) begin
            lvl_one <= (burst.fmt == FMT_525) ? LVL_ONE_C : LVL_ONE_W;
            crc_err <= (burst.fmt == FMT_525) &&
                       (crc6(attr_data[PAY_W-1:0]) != attr_data[DATA_W-1:PAY_W]);
        end
    end

    always_comb begin
        if (!ovr_valid)   ovr_level = '0;
        else if (cur_bit) ovr_level = lvl_one;
        else              ovr_level = LVL_BLANK;
    end

endmodule

// File: rtl/vla_checker.sv
module vla_checker
    import vla_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int LVL_W     = 10,
    parameter int BLANK_LVL = 60,
    parameter int WHITE_LVL = 200,
    parameter int LINE_625  = 23,
    parameter int LINE_5A   = 20,
    parameter int LINE_5B   = 283
) (
    input logic              clk,
    input logic              rst,
    input logic              fmt_525,
    input logic              line_start,
    input logic [LINE_W-1:0] line_num,
    input logic              attr_en,
    input logic              ovr_valid,
    input logic [LVL_W-1:0]  ovr_level,
    input logic              crc_err
);
    localparam logic [LVL_W-1:0] C_BLANK = LVL_W'(BLANK_LVL);
    localparam logic [LVL_W-1:0] C_ONE_W = LVL_W'(frac_level(BLANK_LVL, WHITE_LVL, 5, 7));
    localparam logic [LVL_W-1:0] C_ONE_C = LVL_W'(frac_level(BLANK_LVL, WHITE_LVL, 7, 10));

    logic on_target;
    assign on_target = fmt_525 ? (line_num == LINE_W'(LINE_5A) || line_num == LINE_W'(LINE_5B))
                               : (line_num == LINE_W'(LINE_625));

    p_level_codes_r5: assert property (@(posedge clk) disable iff (rst)
        ovr_valid |-> (ovr_level == C_BLANK || ovr_level == C_ONE_W || ovr_level == C_ONE_C));

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !ovr_valid |-> (ovr_level == '0));

    p_quiet_start_r6: assert property (@(posedge clk) disable iff (rst)
        (line_start && !(attr_en && on_target)) |=> !ovr_valid);

    p_crc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(line_start) |-> $stable(crc_err));

    p_crc_625_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (line_start && attr_en && !fmt_525 && line_num == LINE_W'(LINE_625)) |=> !crc_err);

endmodule

bind vline_attr_inserter vla_checker #(
    .LINE_W   (LINE_W),
    .LVL_W    (LVL_W),
    .BLANK_LVL(BLANK_LVL),
    .WHITE_LVL(WHITE_LVL),
    .LINE_625 (LINE_625),
    .LINE_5A  (LINE_5A),
    .LINE_5B  (LINE_5B)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fmt_525   (fmt_525),
    .line_start(line_start),
    .line_num  (line_num),
    .attr_en   (attr_en),
    .ovr_valid (ovr_valid),
    .ovr_level (ovr_level),
    .crc_err   (crc_err)
);

// File: tb/vline_attr_inserter_tb.sv
module vline_attr_inserter_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        fmt_525;
    logic        line_start;
    logic [9:0]  line_num;
    logic [19:0] attr_data;
    logic        attr_en;
    logic [7:0]  start_ofs;
    logic [3:0]  bit_clks;
    logic        ovr_valid;
    logic [9:0]  ovr_level;
    logic        crc_err;

    int n_vec  = 0;
    int n_fail = 0;
    logic exp_crc = 1'b0;

    always #4 clk = ~clk;

    vline_attr_inserter u_dut (
        .clk(clk), .rst(rst), .fmt_525(fmt_525), .line_start(line_start),
        .line_num(line_num), .attr_data(attr_data), .attr_en(attr_en),
        .start_ofs(start_ofs), .bit_clks(bit_clks), .ovr_valid(ovr_valid),
        .ovr_level(ovr_level), .crc_err(crc_err)
    );

    // R8 rule, written from the requirement
    function automatic logic [5:0] ref_crc(input logic [13:0] d);
        logic [5:0] r = 6'h3F;
        for (int i = 0; i < 14; i++) begin
            if (r[5] != d[i]) r = (r << 1) ^ 6'b000011;
            else              r = r << 1;
        end
        return r;
    endfunction

    function automatic logic is_target(input logic f, input logic [9:0] ln);
        return f ? (ln == 10'd20 || ln == 10'd283) : (ln == 10'd23);
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one line: pulse line_start, then compare each following cycle
    task automatic run_line(input logic f, input logic [9:0] ln, input logic [19:0] d,
                            input logic en, input logic [7:0] ofs, input logic [3:0] bc,
                            input logic midchg, input string tag);
        logic hit = en && is_target(f, ln);
        int nb  = f ? 20 : 14;
        int per = (bc == 0) ? 1 : int'(bc);
        int dur = int'(ofs) + nb * per;
        @(negedge clk);
        fmt_525 = f; line_num = ln; attr_data = d; attr_en = en;
        start_ofs = ofs; bit_clks = bc; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int k = 1; k <= dur + 2; k++) begin
            logic ev;
            logic [9:0] el;
            int j;
            ev = hit && (k >= int'(ofs) + 1) && (k <= dur);
            el = 10'd0;
            if (ev) begin
                j = (k - int'(ofs) - 1) / per;
                el = d[j] ? (f ? 10'd158 : 10'd160) : 10'd60;
            end
            check({ovr_valid, ovr_level} == {ev, el}, tag,
                  int'({ovr_valid, ovr_level}), int'({ev, el}));
            if (midchg && k == 2) begin
                // R7: writes during the line
                attr_data = ~d; attr_en = ~en; start_ofs = ofs + 8'd3; bit_clks = bc + 4'd1;
                fmt_525 = ~f;
            end
            @(negedge clk);
        end
        fmt_525 = f; attr_data = d; attr_en = en; start_ofs = ofs; bit_clks = bc;
        if (hit) exp_crc = f && (ref_crc(d[13:0]) != d[19:14]);
        check(crc_err == exp_crc, "R8 crc_err", int'(crc_err), int'(exp_crc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [19:0] d;
        void'($urandom(32'd4711));
        rst = 1'b1; fmt_525 = 1'b0; line_start = 1'b0; line_num = '0;
        attr_data = '0; attr_en = 1'b0; start_ofs = '0; bit_clks = 4'd1;
        repeat (3) @(negedge clk);
        check({ovr_valid, ovr_level, crc_err} == 12'd0, "R1 in reset",
              int'({ovr_valid, ovr_level, crc_err}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({ovr_valid, ovr_level, crc_err} == 12'd0, "R1 after reset",
              int'({ovr_valid, ovr_level, crc_err}), 0);

        // R2: 625 line, upper bits set but ignored
        run_line(1'b0, 10'd23, 20'hFC000 | 20'h02A5B, 1'b1, 8'd0, 4'd1, 1'b0, "R2 625 lsb first");
        run_line(1'b0, 10'd23, 20'h03FFF, 1'b1, 8'd2, 4'd2, 1'b0, "R2 625 all ones");
        // R3: both 525 lines, good and bad check codes
        d = 20'h01234; d[19:14] = ref_crc(d[13:0]);
        run_line(1'b1, 10'd20, d, 1'b1, 8'd1, 4'd3, 1'b0, "R3 525 line20");
        run_line(1'b1, 10'd283, d ^ 20'h40000, 1'b1, 8'd0, 4'd1, 1'b0, "R3 525 line283 bad crc");
        // R4: bit period zero and maximal offset/period
        run_line(1'b0, 10'd23, 20'h01555, 1'b1, 8'd5, 4'd0, 1'b0, "R4 period zero");
        run_line(1'b1, 10'd20, 20'hAAAAA, 1'b1, 8'd255, 4'd15, 1'b0, "R4 long window");
        // R5: 625 capture clears the flag, one-level 160
        run_line(1'b0, 10'd23, 20'h00001, 1'b1, 8'd0, 4'd1, 1'b0, "R5 one level 625");
        // R6: disabled, off-target lines, 525 target in 625 mode
        run_line(1'b0, 10'd23, 20'h03FFF, 1'b0, 8'd0, 4'd1, 1'b0, "R6 disabled");
        run_line(1'b0, 10'd20, 20'h03FFF, 1'b1, 8'd0, 4'd1, 1'b0, "R6 wrong format line");
        run_line(1'b1, 10'd23, 20'hFFFFF, 1'b1, 8'd0, 4'd1, 1'b0, "R6 off target");
        // R7: mid-line writes
        run_line(1'b1, 10'd283, 20'h5A5A5, 1'b1, 8'd4, 4'd2, 1'b1, "R7 snapshot 525");
        run_line(1'b0, 10'd23, 20'h01C3E, 1'b1, 8'd1, 4'd1, 1'b1, "R7 snapshot 625");

        // R9: burst cut short by another line start
        @(negedge clk);
        fmt_525 = 1'b0; line_num = 10'd23; attr_data = 20'h03FFF; attr_en = 1'b1;
        start_ofs = 8'd0; bit_clks = 4'd4; line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        repeat (3) @(negedge clk);
        check(ovr_valid == 1'b1, "R9 burst running", int'(ovr_valid), 1);
        line_num = 10'd100; line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        for (int k = 0; k < 60; k++) begin
            check(ovr_valid == 1'b0, "R9 abort", int'(ovr_valid), 0);
            @(negedge clk);
        end
        exp_crc = 1'b0;

        // random lines
        for (int n = 0; n < 60; n++) begin
            logic f = 1'($urandom);
            logic [9:0] ln;
            int r = $urandom % 4;
            case (r)
                0: ln = f ? 10'd20 : 10'd23;
                1: ln = f ? 10'd283 : 10'd23;
                2: ln = f ? 10'd21 : 10'd24;
                default: ln = 10'($urandom % 625);
            endcase
            d = 20'($urandom);
            if (f && ($urandom % 2 == 0)) d[19:14] = ref_crc(d[13:0]);
            run_line(f, ln, d, ($urandom % 10) != 0, 8'($urandom % 8), 4'($urandom % 5),
                     ($urandom % 4) == 0, "R4 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule